// File: doc/BRIEF.md
# Linear-Population Routing Switchbox

This block is the switch point where a horizontal and a vertical routing channel cross in a mesh fabric. Each of its four sides (north, east, south, west) carries `TRACKS` tracks. The population is linear: track `i` on one side can join only track `i` on the other three sides. Each track index therefore owns six bidirectional pass switches, one for each unordered pair of sides, and the whole box has `6*TRACKS` switches. A full crossbar would need `6*TRACKS²`.

The bidirectional pass switches are modelled with directional logic. Every side-track has a value input, a drive-valid input and a value output. For each track index, the closed switches split the four sides into connected groups. If exactly one side in a group is driven, every side in that group outputs that side's value. If no side in a group is driven, the group outputs 0. If two or more sides in a group are driven, the group outputs 0 and that index raises its clash flag. The path from inputs to outputs is purely combinational.

The switch settings load one bit per clock through a serial shift chain while `cfg_en` is high. A synchronous active-high reset opens every switch.

Top module: `sbx_linear_switchbox`

## Requirements
- R1: While `rst` is high at a clock edge, every switch opens. With all switches open, each side-track output equals its value input if its drive-valid is high, and 0 otherwise.
- R2: After `6*TRACKS` clocks with `cfg_en` high, stream bit `j` (0-based, first bit sent is `j=0`) sets track `j/6`, pair `j%6`. The pair order is N-E=0, N-S=1, N-W=2, E-S=3, E-W=4, S-W=5. A 1 closes the switch.
- R3: While `cfg_en` is low, `cfg_bit` has no effect and the switch settings keep their value.
- R4: A signal on track `i` never appears on any track with a different index, whatever the switch settings are.
- R5: Connectivity is transitive. Sides joined through a chain of closed switches form one group, and every side in a group with exactly one driven side outputs that side's value.
- R6: A group with no driven side outputs 0 on all of its sides.
- R7: If two or more sides in one group are driven, that group outputs 0, and `clash[i]` is high for that track index. `clash[i]` is low when every group on index `i` has at most one driver.
- R8: The outputs follow the value and drive-valid inputs in the same cycle, without waiting for a clock edge.
- R9: A closed switch carries a value in either direction between its two sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the switch-setting chain |
| rst | input | 1 | Synchronous active-high reset; opens all switches |
| cfg_en | input | 1 | Shift enable for the setting chain |
| cfg_bit | input | 1 | Serial setting bit |
| n_val | input | TRACKS | North side value inputs |
| n_drv | input | TRACKS | North side drive-valid inputs |
| e_val | input | TRACKS | East side value inputs |
| e_drv | input | TRACKS | East side drive-valid inputs |
| s_val | input | TRACKS | South side value inputs |
| s_drv | input | TRACKS | South side drive-valid inputs |
| w_val | input | TRACKS | West side value inputs |
| w_drv | input | TRACKS | West side drive-valid inputs |
| n_out | output | TRACKS | North side outputs |
| e_out | output | TRACKS | East side outputs |
| s_out | output | TRACKS | South side outputs |
| w_out | output | TRACKS | West side outputs |
| clash | output | TRACKS | Per-index flag: a connected group has several drivers |

## Verification
The switch settings are stored state that is not visible at the ports, so any fault in them shows only through routing. A bit stuck open, stuck closed or misplaced in the chain shows up as soon as a single driver is applied on the affected index. It appears as a missing or extra copy of the value on a neighbouring side, or as a wrong `clash`. The bench therefore drives single drivers, pairs of drivers and sparse random drivers after every load. Because routing is combinational, each such error is visible in the same cycle as the stimulus. A mis-ordered chain, by contrast, stays hidden until the loaded pattern is asymmetric, so directed single-bit loads at both ends of the stream are included.

// File: rtl/sbx_pkg.sv
package sbx_pkg;

    localparam int SIDES = 4;
    localparam int PAIRS = 6;

    typedef enum logic [1:0] {
        SIDE_N = 2'd0,
        SIDE_E = 2'd1,
        SIDE_S = 2'd2,
        SIDE_W = 2'd3
    } side_e;

    typedef logic [PAIRS-1:0]            pairmask_t;
    typedef logic [SIDES-1:0]            sidevec_t;
    typedef logic [SIDES-1:0][SIDES-1:0] reach_t;

    typedef struct packed {
        sidevec_t val;
        sidevec_t drv;
    } lane_in_t;

    typedef struct packed {
        sidevec_t val;
        logic     clash;
    } lane_out_t;

    // Switch order within one track index: N-E, N-S, N-W, E-S, E-W, S-W.
    function automatic side_e pair_lo(int p);
        case (p)
            0, 1, 2: return SIDE_N;
            3, 4:    return SIDE_E;
            default: return SIDE_S;
        endcase
    endfunction

    function automatic side_e pair_hi(int p);
        case (p)
            0:       return SIDE_E;
            1, 3:    return SIDE_S;
            default: return SIDE_W;
        endcase
    endfunction

    // One-hop adjacency including self loops.
    function automatic reach_t adjacency(pairmask_t sw);
        reach_t r;
        r = '0;
        for (int s = 0; s < SIDES; s++) r[s][s] = 1'b1;
        for (int p = 0; p < PAIRS; p++) begin
            if (sw[p]) begin
                r[int'(pair_lo(p))][int'(pair_hi(p))] = 1'b1;
                r[int'(pair_hi(p))][int'(pair_lo(p))] = 1'b1;
            end
        end
        return r;
    endfunction

    // Boolean matrix product: paths of x followed by paths of y.
    function automatic reach_t compose(reach_t x, reach_t y);
        reach_t r;
        r = '0;
        for (int i = 0; i < SIDES; i++)
            for (int j = 0; j < SIDES; j++)
                for (int k = 0; k < SIDES; k++)
                    r[i][j] = r[i][j] | (x[i][k] & y[k][j]);
        return r;
    endfunction

endpackage

// File: rtl/sbx_cfg_chain.sv
module sbx_cfg_chain
    import sbx_pkg::*;
#(
    parameter int TRACKS = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         shift_en,
    input  logic                         shift_in,
    output logic [TRACKS-1:0][PAIRS-1:0] sw
);
    localparam int TOTAL = TRACKS * PAIRS;

    logic [TOTAL-1:0] bits_q;

    // New bits enter at the top; the first bit sent ends at position 0.
    always_ff @(posedge clk) begin
        if (rst)
            bits_q <= '0;
        else if (shift_en)
            bits_q <= {shift_in, bits_q[TOTAL-1:1]};
    end

    for (genvar t = 0; t < TRACKS; t++) begin : g_slice
        assign sw[t] = bits_q[t*PAIRS +: PAIRS];
    end

    a_r1_reset_opens: assert property (@(posedge clk)
        rst |=> (bits_q == '0));

    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(bits_q));

    a_r2_entry_bit: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (bits_q[TOTAL-1] == $past(shift_in)));

endmodule

// File: rtl/sbx_lane.sv
module sbx_lane
    import sbx_pkg::*;
(
    input  pairmask_t sw,
    input  lane_in_t  din,
    output lane_out_t dout
);
    reach_t hop1;
    reach_t hop2;
    reach_t hop4;

    always_comb begin
        hop1 = adjacency(sw);
        hop2 = compose(hop1, hop1);
        hop4 = compose(hop2, hop2);
    end

    sidevec_t grp_drv [SIDES];
    logic [2:0] grp_cnt [SIDES];

    always_comb begin
        dout.clash = 1'b0;
        for (int s = 0; s < SIDES; s++) begin
            grp_drv[s] = hop4[s] & din.drv;
            grp_cnt[s] = 3'($countones(grp_drv[s]));
            dout.val[s] = (grp_cnt[s] == 3'd1) ? |(grp_drv[s] & din.val) : 1'b0;
            if (grp_cnt[s] > 3'd1) dout.clash = 1'b1;
        end
    end

endmodule

// File: rtl/sbx_linear_switchbox.sv
module sbx_linear_switchbox
    import sbx_pkg::*;
#(
    parameter int TRACKS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              cfg_bit,
    input  logic [TRACKS-1:0] n_val,
    input  logic [TRACKS-1:0] n_drv,
    input  logic [TRACKS-1:0] e_val,
    input  logic [TRACKS-1:0] e_drv,
    input  logic [TRACKS-1:0] s_val,
    input  logic [TRACKS-1:0] s_drv,
    input  logic [TRACKS-1:0] w_val,
    input  logic [TRACKS-1:0] w_drv,
    output logic [TRACKS-1:0] n_out,
    output logic [TRACKS-1:0] e_out,
    output logic [TRACKS-1:0] s_out,
    output logic [TRACKS-1:0] w_out,
    output logic [TRACKS-1:0] clash
);
    logic [TRACKS-1:0][PAIRS-1:0] sw;

    sbx_cfg_chain #(.TRACKS(TRACKS)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_en),
        .shift_in (cfg_bit),
        .sw       (sw)
    );

    lane_in_t  li [TRACKS];
    lane_out_t lo [TRACKS];

    for (genvar t = 0; t < TRACKS; t++) begin : g_track
        assign li[t].val = {w_val[t], s_val[t], e_val[t], n_val[t]};
        assign li[t].drv = {w_drv[t], s_drv[t], e_drv[t], n_drv[t]};

        sbx_lane u_lane (
            .sw   (sw[t]),
            .din  (li[t]),
            .dout (lo[t])
        );

        assign n_out[t] = lo[t].val[SIDE_N];
        assign e_out[t] = lo[t].val[SIDE_E];
        assign s_out[t] = lo[t].val[SIDE_S];
        assign w_out[t] = lo[t].val[SIDE_W];
        assign clash[t] = lo[t].clash;

        a_r1_open_isolated: assert property (@(posedge clk) disable iff (rst)
            (sw[t] == '0) |-> (lo[t].val == (li[t].val & li[t].drv)) && !lo[t].clash);

        a_r6_undriven_zero: assert property (@(posedge clk) disable iff (rst)
            (li[t].drv == '0) |-> (lo[t].val == '0) && !lo[t].clash);

        for (genvar p = 0; p < PAIRS; p++) begin : g_pair
            localparam int SA = int'(pair_lo(p));
            localparam int SB = int'(pair_hi(p));
            a_r9_closed_equal: assert property (@(posedge clk) disable iff (rst)
                sw[t][p] |-> (lo[t].val[SA] == lo[t].val[SB]));
        end
    end

endmodule

// File: tb/sbx_linear_switchbox_tb.sv
module sbx_linear_switchbox_tb;
    localparam int TR  = 4;
    localparam int TOT = TR * 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_en = 1'b0;
    logic cfg_bit = 1'b0;
    logic [TR-1:0] n_val = '0, n_drv = '0, e_val = '0, e_drv = '0;
    logic [TR-1:0] s_val = '0, s_drv = '0, w_val = '0, w_drv = '0;
    logic [TR-1:0] n_out, e_out, s_out, w_out, clash;

    int checks = 0;
    int fails  = 0;
    logic [5:0] shcfg [TR];

    always #5 clk = ~clk;

    sbx_linear_switchbox #(.TRACKS(TR)) u_dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
        .n_val(n_val), .n_drv(n_drv), .e_val(e_val), .e_drv(e_drv),
        .s_val(s_val), .s_drv(s_drv), .w_val(w_val), .w_drv(w_drv),
        .n_out(n_out), .e_out(e_out), .s_out(s_out), .w_out(w_out),
        .clash(clash)
    );

    function automatic int side_a(int p);
        case (p) 0, 1, 2: return 0; 3, 4: return 1; default: return 2; endcase
    endfunction
    function automatic int side_b(int p);
        case (p) 0: return 1; 1, 3: return 2; default: return 3; endcase
    endfunction

    // Reference: label propagation over closed switches, then count drivers.
    function automatic void model(input logic [5:0] sw, input logic [3:0] v,
                                  input logic [3:0] d, output logic [3:0] o,
                                  output logic c);
        int lab [4];
        for (int s = 0; s < 4; s++) lab[s] = s;
        repeat (4) begin
            for (int p = 0; p < 6; p++) begin
                if (sw[p]) begin
                    int m;
                    m = (lab[side_a(p)] < lab[side_b(p)]) ? lab[side_a(p)] : lab[side_b(p)];
                    lab[side_a(p)] = m;
                    lab[side_b(p)] = m;
                end
            end
        end
        c = 1'b0;
        for (int s = 0; s < 4; s++) begin
            int cnt;
            logic x;
            cnt = 0;
            x = 1'b0;
            for (int t = 0; t < 4; t++)
                if (lab[t] == lab[s] && d[t]) begin cnt++; x = v[t]; end
            o[s] = (cnt == 1) ? x : 1'b0;
            if (cnt > 1) c = 1'b1;
        end
    endfunction

    task automatic check(string req);
        logic [TR-1:0] xn, xe, xs, xw, xc;
        for (int i = 0; i < TR; i++) begin
            logic [3:0] o;
            logic c;
            model(shcfg[i], {w_val[i], s_val[i], e_val[i], n_val[i]},
                  {w_drv[i], s_drv[i], e_drv[i], n_drv[i]}, o, c);
            xn[i] = o[0]; xe[i] = o[1]; xs[i] = o[2]; xw[i] = o[3]; xc[i] = c;
        end
        checks++;
        if ({n_out, e_out, s_out, w_out, clash} !== {xn, xe, xs, xw, xc}) begin
            fails++;
            $display("FAIL %s: got n=%b e=%b s=%b w=%b clash=%b exp n=%b e=%b s=%b w=%b clash=%b",
                     req, n_out, e_out, s_out, w_out, clash, xn, xe, xs, xw, xc);
        end
    endtask

    task automatic drive(logic [TR-1:0] nv, nd, ev, ed, sv, sd, wv, wd);
        n_val = nv; n_drv = nd; e_val = ev; e_drv = ed;
        s_val = sv; s_drv = sd; w_val = wv; w_drv = wd;
        #1;
    endtask

    task automatic load();
        for (int j = 0; j < TOT; j++) begin
            @(negedge clk);
            cfg_en  = 1'b1;
            cfg_bit = shcfg[j / 6][j % 6];
        end
        @(negedge clk);
        cfg_en = 1'b0;
        cfg_bit = 1'b0;
    endtask

    task automatic set_all(logic [5:0] v);
        for (int i = 0; i < TR; i++) shcfg[i] = v;
    endtask

    task automatic rand_inputs();
        logic [TR-1:0] r [8];
        for (int k = 0; k < 8; k++) r[k] = TR'($urandom);
        // sparse drivers: roughly one side in four
        drive(r[0], r[1] & TR'($urandom), r[2], r[3] & TR'($urandom),
              r[4], r[5] & TR'($urandom), r[6], r[7] & TR'($urandom));
    endtask

    bit done = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        set_all(6'b0);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: after reset every switch is open
        drive('1, 4'b1010, '0, 4'b0101, 4'b0110, 4'b1100, '1, 4'b0011);
        check("R1 reset open");
        if (n_out !== 4'b1010 || e_out !== 4'b0000) begin
            checks++; fails++;
            $display("FAIL R1 open: got n=%b e=%b exp n=1010 e=0000", n_out, e_out);
        end else checks++;

        // R2: single bit at stream start -> track0 N-E only
        set_all(6'b0); shcfg[0] = 6'b000001; load();
        drive(4'b0001, 4'b0001, '0, '0, '0, '0, '0, '0);
        checks++;
        if (e_out !== 4'b0001 || s_out !== 4'b0000 || w_out !== 4'b0000) begin
            fails++;
            $display("FAIL R2 first bit: got e=%b s=%b w=%b exp e=0001 s=0000 w=0000", e_out, s_out, w_out);
        end
        // R2: last bit in stream -> top track S-W
        set_all(6'b0); shcfg[TR-1] = 6'b100000; load();
        drive('0, '0, '0, '0, '1, '1, '0, '0);
        check("R2 last bit");
        checks++;
        if (w_out !== 4'b1000) begin
            fails++;
            $display("FAIL R2 last bit: got w=%b exp w=1000", w_out);
        end

        // R3: cfg_en low, cfg_bit toggling has no effect
        set_all(6'b010101); load();
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); cfg_bit = k[0];
        end
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin rand_inputs(); check("R3 hold"); end

        // all closed: R5 single driver, R6 no driver, R7 two drivers, R4 domain
        set_all(6'b111111); load();
        drive(4'b0001, 4'b0001, '0, '0, '0, '0, '0, '0);
        check("R5 all closed single driver");
        checks++;
        if (w_out !== 4'b0001 || s_out !== 4'b0001 || e_out !== 4'b0001) begin
            fails++;
            $display("FAIL R4 domain: got e=%b s=%b w=%b exp 0001", e_out, s_out, w_out);
        end
        drive('1, '0, '1, '0, '1, '0, '1, '0);
        check("R6 undriven group");
        drive(4'b0100, 4'b0100, '0, '0, 4'b0100, 4'b0100, '0, '0);
        check("R7 two drivers");
        checks++;
        if (clash !== 4'b0100 || n_out !== 4'b0000) begin
            fails++;
            $display("FAIL R7 clash: got clash=%b n=%b exp clash=0100 n=0000", clash, n_out);
        end

        // R5 transitive: N-E and E-S closed -> N reaches S
        set_all(6'b001001); load();
        drive(4'b1111, 4'b1111, '0, '0, '0, '0, 4'b1010, 4'b1111);
        check("R5 chained");
        checks++;
        if (s_out !== 4'b1111) begin
            fails++;
            $display("FAIL R5 chained: got s=%b exp 1111", s_out);
        end

        // R9: E-W only, both directions
        set_all(6'b010000); load();
        drive('0, '0, '0, '0, '0, '0, 4'b1011, '1);
        check("R9 west to east");
        drive('0, '0, 4'b0110, '1, '0, '0, '0, '0);
        check("R9 east to west");

        // R8: inputs change between edges, outputs follow
        #2;
        drive('0, '0, 4'b1001, '1, '0, '0, '0, '0);
        check("R8 combinational");

        // random configurations
        for (int it = 0; it < 15; it++) begin
            for (int i = 0; i < TR; i++) shcfg[i] = 6'($urandom);
            load();
            for (int k = 0; k < 20; k++) begin rand_inputs(); check("R5 R7 random"); end
        end

        // R1: reset clears a loaded configuration
        set_all(6'b111111); load();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        set_all(6'b0);
        drive(4'b1100, '1, '0, '0, '0, '0, '0, '0);
        check("R1 reset reopens");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule